// File: doc/BRIEF.md
# Time-Shared Output Driver Selector

Several mutually exclusive dynamic tasks take turns on one region of a reconfigurable array, and any of them may drive one shared signal. This block decides, every cycle, which task is the legitimate driver and whether the value on the shared signal can be trusted. Each task presents a data word and three status inputs: running, reconfiguring, and the direction of the reconfiguration. A pulse reports the end of a controlled deactivation. The block returns the selected data word, a valid bit that stands in for an unknown value, the index of the chosen task, the priority level that won, and a conflict flag.

The choice follows four levels. A reconfiguring task wins first, and its output is unknown. A running task comes next. After that comes the power-on default left by the most recent controlled deactivation, which is logic 0 and is valid only while no configuration has started loading since. When none of these applies, there is no driver. Each task also has an initialization gate. The gate keeps the task's output invalid after activation. A parameter picks one of two variants for each task: the first counts a programmed number of cycles, which models flushing a pipeline with data; the second waits for a reset-done input to rise.

Top module: `shared_drive_sel`

## Requirements
- R1: When any task has its reconfiguring input high, the level output is 3 (reconfiguring), the select output is the lowest such index, and valid is 0.
- R2: When no task is reconfiguring and at least one is running, the level output is 2 (active) and the select output is the lowest running index. Once that task's gate is open, the data output equals that task's data word with valid 1.
- R3: When no task is reconfiguring or running and a controlled-deactivation record exists, the level output is 1 (default), valid is 1 and data is 0. A deactivate-done pulse creates the record from the next cycle on.
- R4: The record is cleared on the clock edge after any task is reconfiguring with direction 1 (activating). A transition with direction 0 (deactivating) leaves the record in place.
- R5: A task that stops running without a deactivate-done pulse leaves no valid driver: the level output is 0 (none) and valid is 0.
- R6: A counter-gated task (tasks 0 and 1 by default) with init count C on the first cycle it runs gives valid 0 for C cycles and valid 1 from the C-th following cycle. With C = 0 it is valid at once.
- R7: A reset-gated task (tasks 2 and 3 by default) stays invalid after activation until its reset-done input rises. It becomes valid in the cycle after the rise is seen.
- R8: When more than one task qualifies at the winning level (reconfiguring or active), the lowest index is selected and conflict is 1. Otherwise conflict is 0.
- R9: After reset the level output is 0, valid is 0, data is 0, and no record exists.
- R10: Whenever valid is 0, the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_data_i | input | N_TASKS*DATA_W | Data word from each task |
| task_active_i | input | N_TASKS | Task is configured and running |
| task_trans_i | input | N_TASKS | Task is being reconfigured |
| task_act_dir_i | input | N_TASKS | Direction of reconfiguration: 1 activating, 0 deactivating |
| deact_done_i | input | N_TASKS | One-cycle pulse when a controlled deactivation completes |
| rst_done_i | input | N_TASKS | Reset-done input for reset-gated tasks |
| init_cycles_i | input | CNT_W | Post-activation mask length for counter-gated tasks |
| drv_data_o | output | DATA_W | Selected data word |
| drv_valid_o | output | 1 | Output is known |
| drv_sel_o | output | IDX_W | Index of the selected task |
| drv_level_o | output | 2 | Winning level: 0 none, 1 default, 2 active, 3 reconfiguring |
| conflict_o | output | 1 | More than one task at the winning level |

## Verification
The assertions assume the inputs are legal for a mutex set. Deactivate-done arrives as a single-cycle pulse, and the direction input matters only while a task is reconfiguring. A task's reset-done input does not rise in the cycle it starts running. The bench drives all inputs on the falling edge and returns to an idle state between scenarios. The only overlap it creates between tasks is the deliberate one used to exercise the conflict flag.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_DFLT  = 2'd1,
    LVL_ACT   = 2'd2,
    LVL_RECFG = 2'd3
  } lvl_e;
endpackage

// File: rtl/sds_prio_pick.sv
module sds_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o   = |req_i;
  assign multi_o = |(req_i & (req_i - N'(1)));
endmodule

// File: rtl/sds_init_gate.sv
module sds_init_gate #(
  parameter bit RST_MODE = 1'b0,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rst_done_i,
  input  logic [CNT_W-1:0] init_cycles_i,
  output logic             open_o
);
  logic run_q;
  logic run_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end
  assign run_rise = run_i & ~run_q;

  if (RST_MODE) begin : g_rst
    logic done_q, blk_q, done_rise;
    logic [CNT_W-1:0] unused_cnt;
    assign unused_cnt = init_cycles_i;
    assign done_rise  = rst_done_i & ~done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q <= 1'b0;
        blk_q  <= 1'b0;
      end else begin
        done_q <= rst_done_i;
        blk_q  <= (run_rise | blk_q) & ~done_rise;
      end
    end
    assign open_o = run_i & ~run_rise & ~blk_q;
  end else begin : g_cnt
    logic [CNT_W-1:0] cnt_q, remain;
    logic unused_done;
    assign unused_done = rst_done_i;
    assign remain = run_rise ? init_cycles_i : cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (remain != '0) cnt_q <= remain - CNT_W'(1);
      else                   cnt_q <= '0;
    end
    assign open_o = run_i & (remain == '0);
  end
endmodule

// File: rtl/sds_deact_rec.sv
module sds_deact_rec #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     deact_done_i,
  input  logic [N-1:0]     activating_i,
  output logic             rec_vld_o,
  output logic [IDX_W-1:0] rec_idx_o
);
  logic             pulse_any;
  logic [IDX_W-1:0] pulse_idx;
  logic             unused_multi;

  sds_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req_i   (deact_done_i),
    .any_o   (pulse_any),
    .idx_o   (pulse_idx),
    .multi_o (unused_multi)
  );

  // a configuration starting to load overwrites the default image
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_vld_o <= 1'b0;
      rec_idx_o <= '0;
    end else if (|activating_i) begin
      rec_vld_o <= 1'b0;
    end else if (pulse_any) begin
      rec_vld_o <= 1'b1;
      rec_idx_o <= pulse_idx;
    end
  end
endmodule

// File: rtl/shared_drive_sel.sv
module shared_drive_sel
  import sds_pkg::*;
#(
  parameter int               N_TASKS  = 4,
  parameter int               DATA_W   = 8,
  parameter int               CNT_W    = 8,
  parameter logic [N_TASKS-1:0] GATE_RST = 4'b1100,
  localparam int              IDX_W    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_TASKS-1:0][DATA_W-1:0] task_data_i,
  input  logic [N_TASKS-1:0]             task_active_i,
  input  logic [N_TASKS-1:0]             task_trans_i,
  input  logic [N_TASKS-1:0]             task_act_dir_i,
  input  logic [N_TASKS-1:0]             deact_done_i,
  input  logic [N_TASKS-1:0]             rst_done_i,
  input  logic [CNT_W-1:0]               init_cycles_i,
  output logic [DATA_W-1:0]              drv_data_o,
  output logic                           drv_valid_o,
  output logic [IDX_W-1:0]               drv_sel_o,
  output logic [1:0]                     drv_level_o,
  output logic                           conflict_o
);
  logic [N_TASKS-1:0] running, gate_open;
  logic               rc_any, rc_multi, ac_any, ac_multi, rec_vld;
  logic [IDX_W-1:0]   rc_idx, ac_idx, rec_idx;
  lvl_e               lvl;

  assign running = task_active_i & ~task_trans_i;

  for (genvar i = 0; i < N_TASKS; i++) begin : g_gate
    sds_init_gate #(.RST_MODE(GATE_RST[i]), .CNT_W(CNT_W)) u_gate (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .run_i         (running[i]),
      .rst_done_i    (rst_done_i[i]),
      .init_cycles_i (init_cycles_i),
      .open_o        (gate_open[i])
    );
  end

  sds_prio_pick #(.N(N_TASKS), .IDX_W(IDX_W)) u_rc (
    .req_i (task_trans_i), .any_o (rc_any), .idx_o (rc_idx), .multi_o (rc_multi)
  );
  sds_prio_pick #(.N(N_TASKS), .IDX_W(IDX_W)) u_ac (
    .req_i (running), .any_o (ac_any), .idx_o (ac_idx), .multi_o (ac_multi)
  );

  sds_deact_rec #(.N(N_TASKS), .IDX_W(IDX_W)) u_rec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .deact_done_i (deact_done_i),
    .activating_i (task_trans_i & task_act_dir_i),
    .rec_vld_o    (rec_vld),
    .rec_idx_o    (rec_idx)
  );

  always_comb begin
    lvl         = LVL_NONE;
    drv_sel_o   = '0;
    drv_valid_o = 1'b0;
    drv_data_o  = '0;
    conflict_o  = 1'b0;
    if (rc_any) begin
      lvl        = LVL_RECFG;
      drv_sel_o  = rc_idx;
      conflict_o = rc_multi;
    end else if (ac_any) begin
      lvl         = LVL_ACT;
      drv_sel_o   = ac_idx;
      conflict_o  = ac_multi;
      drv_valid_o = gate_open[ac_idx];
      drv_data_o  = gate_open[ac_idx] ? task_data_i[ac_idx] : '0;
    end else if (rec_vld) begin
      lvl         = LVL_DFLT;
      drv_sel_o   = rec_idx;
      drv_valid_o = 1'b1;
    end
  end
  assign drv_level_o = lvl;
endmodule

// File: rtl/shared_drive_sel_chk.sv
module shared_drive_sel_chk #(
  parameter int N_TASKS = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_TASKS-1:0]             task_active_i,
  input logic [N_TASKS-1:0]             task_trans_i,
  input logic [N_TASKS-1:0]             task_act_dir_i,
  input logic [DATA_W-1:0]              drv_data_o,
  input logic                           drv_valid_o,
  input logic [IDX_W-1:0]               drv_sel_o,
  input logic [1:0]                     drv_level_o,
  input logic                           conflict_o
);
  // R1
  recfg_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |task_trans_i |-> (!drv_valid_o && drv_level_o == 2'd3 && task_trans_i[drv_sel_o]));
  // R10
  zero_when_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_valid_o |-> drv_data_o == '0);
  // R2
  active_sel_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_level_o == 2'd2 |-> (task_active_i[drv_sel_o] && !(|task_trans_i)));
  // R3
  default_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_level_o == 2'd1 |-> (drv_valid_o && drv_data_o == '0 && !(|task_active_i)));
  // R4
  record_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(task_trans_i & task_act_dir_i) |=> drv_level_o != 2'd1);
  // R8
  conflict_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> drv_level_o[1]);
endmodule

bind shared_drive_sel shared_drive_sel_chk #(
  .N_TASKS(N_TASKS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .task_active_i  (task_active_i),
  .task_trans_i   (task_trans_i),
  .task_act_dir_i (task_act_dir_i),
  .drv_data_o     (drv_data_o),
  .drv_valid_o    (drv_valid_o),
  .drv_sel_o      (drv_sel_o),
  .drv_level_o    (drv_level_o),
  .conflict_o     (conflict_o)
);

// File: tb/sim_shared_drive_sel.sv
module sim_shared_drive_sel;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, DW = 8, CW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0][DW-1:0] task_data_i;
  logic [N-1:0] task_active_i, task_trans_i, task_act_dir_i, deact_done_i, rst_done_i;
  logic [CW-1:0] init_cycles_i;
  logic [DW-1:0] drv_data_o;
  logic drv_valid_o, conflict_o;
  logic [1:0] drv_sel_o, drv_level_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shared_drive_sel u0 (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, int lvl, int vld, int data, int sel, int cf);
    #1;
    chk({req, " level"}, drv_level_o, lvl);
    chk({req, " valid"}, drv_valid_o, vld);
    chk({req, " data"}, drv_data_o, data);
    chk({req, " sel"}, drv_sel_o, sel);
    chk({req, " conflict"}, conflict_o, cf);
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic idle();
    task_active_i = '0; task_trans_i = '0; task_act_dir_i = '0;
    deact_done_i = '0; rst_done_i = '0;
    tick(); tick();
  endtask

  task automatic t_reset();
    expect_out("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority();
    idle();
    init_cycles_i = '0;
    task_active_i = 4'b0010;
    expect_out("R2", 2, 1, 8'h22, 1, 0);
    task_trans_i = 4'b0100; task_act_dir_i = 4'b0100;
    expect_out("R1", 3, 0, 0, 2, 0);
    task_trans_i = 4'b1100;
    expect_out("R8 recfg", 3, 0, 0, 2, 1);
    tick();
    task_trans_i = '0; task_act_dir_i = '0;
    task_active_i = 4'b0011;
    expect_out("R8 active", 2, 1, 8'h11, 0, 1);
    tick();
    task_active_i = 4'b0010;
    expect_out("R2 single", 2, 1, 8'h22, 1, 0);
    tick();
    task_active_i = '0;
    expect_out("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_cnt_gate();
    idle();
    init_cycles_i = 8'd3;
    task_active_i = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      expect_out("R6 masked", 2, 0, 0, 0, 0);
      tick();
    end
    expect_out("R6 open", 2, 1, 8'h11, 0, 0);
  endtask

  task automatic t_rst_gate();
    idle();
    task_active_i = 4'b0100;
    expect_out("R7 masked", 2, 0, 0, 2, 0);
    tick(); tick();
    expect_out("R7 still masked", 2, 0, 0, 2, 0);
    rst_done_i = 4'b0100;
    expect_out("R7 rise seen", 2, 0, 0, 2, 0);
    tick();
    expect_out("R7 open", 2, 1, 8'h33, 2, 0);
  endtask

  task automatic t_deact();
    idle();
    deact_done_i = 4'b0010;
    expect_out("R3 before edge", 0, 0, 0, 0, 0);
    tick();
    deact_done_i = '0;
    expect_out("R3 default", 1, 1, 0, 1, 0);
    task_trans_i = 4'b0001; task_act_dir_i = 4'b0000;
    tick();
    task_trans_i = '0;
    expect_out("R4 deactivating keeps", 1, 1, 0, 1, 0);
    task_trans_i = 4'b1000; task_act_dir_i = 4'b1000;
    expect_out("R1 over default", 3, 0, 0, 3, 0);
    tick();
    task_trans_i = '0; task_act_dir_i = '0;
    expect_out("R4 cleared", 0, 0, 0, 0, 0);
  endtask

  initial begin
    task_data_i = {8'h44, 8'h33, 8'h22, 8'h11};
    task_active_i = '0; task_trans_i = '0; task_act_dir_i = '0;
    deact_done_i = '0; rst_done_i = '0; init_cycles_i = '0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_cnt_gate();
    t_rst_gate();
    t_deact();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule